// File: doc/BRIEF.md
# Mobile DRAM Clock-Enable Power-State Tracker

This block follows the low-power behaviour of a mobile double-data-rate SDRAM as the controller drives its clock-enable line. On every rising clock edge it compares the clock-enable level held from the previous edge with the present level. It also looks at a decoded command code and at a flag that is high while any bank holds an open row. From these inputs it picks the next power state: normal, active power-down, precharge power-down, self refresh or deep power-down. For that edge it reports what happened as an action code that is valid for one cycle.

A falling clock-enable edge selects the mode. The mode depends on the command seen with the falling edge and on whether a bank is open. A rising edge that carries an idle command (no-operation or deselect) leaves the mode. After such an exit, a down-counter guards the exit window. Every edge inside the window must carry clock-enable high and an idle command. Leaving deep power-down raises a sticky flag that demands a fresh initialisation. Every other combination pulses an illegal flag for one cycle. The block suits a controller-side protocol monitor or a memory model used in simulation.

Top module: `lp_cke_tracker`

## Requirements
- R1: After reset the outputs read pstate = 0 (normal), action = 0 (none), illegal = 0 and reinit_req = 0. The clock-enable level remembered from the previous edge resets to high.
- R2: In the normal state, outside any exit window and with no pending reinitialisation, a falling edge (previous high, current low) carrying an idle command moves the block to active power-down if bank_open = 1. It sets pstate = 1 and action = 1. Idle commands are cmd = 0 (no-operation) and cmd = 1 (deselect).
- R3: The same falling edge with an idle command and bank_open = 0 moves the block to precharge power-down, with pstate = 2 and action = 2.
- R4: A falling edge with bank_open = 0 and cmd = 2 (auto refresh) enters self refresh (pstate = 3, action = 3). A falling edge with bank_open = 0 and cmd = 4 (burst terminate) enters deep power-down (pstate = 4, action = 4).
- R5: In any low-power state, an edge with clock-enable low keeps the state and ignores the command. It sets action = 4 + pstate (5 to 8) and illegal = 0.
- R6: In a low-power state, clock-enable high with an idle command returns the block to normal, with action = 8 + the old pstate (9 to 12). Clock-enable high with any other command sets illegal = 1 and keeps the state.
- R7: An exit from self refresh starts a window of max(T_XSR, 2) edges. An exit from either power-down mode starts a window of T_XP edges. Within the window, an edge in the normal state with clock-enable low or a non-idle command sets illegal = 1 and makes no state change.
- R8: Leaving deep power-down sets reinit_req, which stays set until an edge with init_done = 1. Setting takes priority over clearing. While reinit_req is set, a non-idle command in the normal state sets illegal = 1 and starts no low-power entry.
- R9: In the normal state, a falling edge with any other command or bank combination sets illegal = 1 and keeps the normal state. An edge whose previous clock-enable level was low while in the normal state also sets illegal = 1 and keeps the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; all decisions on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock-enable level at the current edge |
| cmd | input | 3 | Decoded command: 0 no-operation, 1 deselect, 2 auto refresh, 4 burst terminate, others general |
| bank_open | input | 1 | High while any bank has an open row |
| init_done | input | 1 | Pulse marking a completed initialisation; clears reinit_req |
| pstate | output | 3 | Power state: 0 normal, 1 active PD, 2 precharge PD, 3 self refresh, 4 deep PD |
| action | output | 4 | Action of the last edge: 0 none, 1-4 entry, 5-8 maintain, 9-12 exit |
| illegal | output | 1 | One-cycle flag for an illegal clock-enable/command sequence |
| reinit_req | output | 1 | Sticky flag: initialisation required after deep power-down |

## Verification
The state register shows up on pstate in the cycle after the edge that set it. The action code is produced together with the state, so a wrong transition shows at the ports on the very next edge. A stale clock-enable memory or a miscounted exit window is less visible: at first it only moves the illegal pulse. The bench therefore compares the illegal flag on every cycle. It drives commands and clock-enable changes right after each exit, so that an off-by-one window length shows up within one to four edges. A lost or early-cleared reinit_req shows up on the first general command after a deep power-down exit.

// File: rtl/lp_cke_pkg.sv
package lp_cke_pkg;

    localparam int CMD_W = 3;
    localparam int ACT_W = 4;

    localparam logic [CMD_W-1:0] CMD_NOP   = 3'd0;
    localparam logic [CMD_W-1:0] CMD_DESEL = 3'd1;
    localparam logic [CMD_W-1:0] CMD_AREF  = 3'd2;
    localparam logic [CMD_W-1:0] CMD_BTERM = 3'd4;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_ACT_PD = 3'd1,
        ST_PRE_PD = 3'd2,
        ST_SELF   = 3'd3,
        ST_DEEP   = 3'd4
    } pstate_e;

    localparam logic [ACT_W-1:0] ACT_NONE       = 4'd0;
    localparam logic [ACT_W-1:0] ACT_ENTER_BASE = 4'd0;
    localparam logic [ACT_W-1:0] ACT_HOLD_BASE  = 4'd4;
    localparam logic [ACT_W-1:0] ACT_EXIT_BASE  = 4'd8;

    typedef struct packed {
        pstate_e          st;
        logic             cke;
        logic [ACT_W-1:0] act;
        logic             ill;
        logic             reinit;
    } trk_t;

endpackage

// File: rtl/lp_cmd_class.sv
module lp_cmd_class
    import lp_cke_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output logic             is_idle,
    output logic             is_aref,
    output logic             is_bterm
);
    always_comb begin
        is_idle  = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
        is_aref  = (cmd == CMD_AREF);
        is_bterm = (cmd == CMD_BTERM);
    end
endmodule

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = load_val;
        else if (count_q != '0)
            count_d = count_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign busy = (count_q != '0);

    // R7
    window_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (count_q == $past(count_q) - CNT_W'(1)));

endmodule

// File: rtl/lp_cke_tracker.sv
module lp_cke_tracker
    import lp_cke_pkg::*;
#(
    parameter int T_XP  = 2,
    parameter int T_XSR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [CMD_W-1:0] cmd,
    input  logic             bank_open,
    input  logic             init_done,
    output logic [2:0]       pstate,
    output logic [ACT_W-1:0] action,
    output logic             illegal,
    output logic             reinit_req
);
    localparam int XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
    localparam int WIN_MAX = (XSR_EFF > T_XP) ? XSR_EFF : T_XP;
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    trk_t             trk_d, trk_q;
    logic             idle_cmd, aref_cmd, bterm_cmd;
    logic             win_busy, win_load;
    logic [CNT_W-1:0] win_val;

    lp_cmd_class u_class (
        .cmd      (cmd),
        .is_idle  (idle_cmd),
        .is_aref  (aref_cmd),
        .is_bterm (bterm_cmd)
    );

    lp_exit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_val),
        .busy     (win_busy)
    );

    always_comb begin
        trk_d        = trk_q;
        trk_d.cke    = cke;
        trk_d.act    = ACT_NONE;
        trk_d.ill    = 1'b0;
        win_load     = 1'b0;
        win_val      = CNT_W'(T_XP);

        if (trk_q.st == ST_NORMAL) begin
            if (!trk_q.cke) begin
                trk_d.ill = 1'b1;
            end else if (win_busy) begin
                trk_d.ill = !cke || !idle_cmd;
            end else if (trk_q.reinit && !idle_cmd) begin
                trk_d.ill = 1'b1;
            end else if (!cke) begin
                if (idle_cmd) begin
                    trk_d.st  = bank_open ? ST_ACT_PD : ST_PRE_PD;
                end else if (aref_cmd && !bank_open) begin
                    trk_d.st  = ST_SELF;
                end else if (bterm_cmd && !bank_open) begin
                    trk_d.st  = ST_DEEP;
                end else begin
                    trk_d.ill = 1'b1;
                end
                if (!trk_d.ill)
                    trk_d.act = ACT_ENTER_BASE + ACT_W'(trk_d.st);
            end
        end else begin
            if (!cke) begin
                trk_d.act = ACT_HOLD_BASE + ACT_W'(trk_q.st);
            end else if (idle_cmd) begin
                trk_d.st  = ST_NORMAL;
                trk_d.act = ACT_EXIT_BASE + ACT_W'(trk_q.st);
                win_load  = 1'b1;
                win_val   = (trk_q.st == ST_SELF) ? CNT_W'(XSR_EFF) : CNT_W'(T_XP);
            end else begin
                trk_d.ill = 1'b1;
            end
        end

        if (trk_q.st == ST_DEEP && cke && idle_cmd)
            trk_d.reinit = 1'b1;
        else if (init_done)
            trk_d.reinit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.st     <= ST_NORMAL;
            trk_q.cke    <= 1'b1;
            trk_q.act    <= ACT_NONE;
            trk_q.ill    <= 1'b0;
            trk_q.reinit <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pstate     = trk_q.st;
    assign action     = trk_q.act;
    assign illegal    = trk_q.ill;
    assign reinit_req = trk_q.reinit;

    // R5
    hold_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st != ST_NORMAL && !cke) |=> (trk_q.st == $past(trk_q.st) && !trk_q.ill));

    // R6
    exit_to_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st != ST_NORMAL && cke && idle_cmd) |=> (trk_q.st == ST_NORMAL));

    // R4
    entry_needs_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == ST_NORMAL && cke) |=> (trk_q.st == ST_NORMAL));

    // R7
    window_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == ST_NORMAL && win_busy && !idle_cmd) |=> trk_q.ill);

    // R8
    reinit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.reinit && !init_done) |=> trk_q.reinit);

    // R8
    reinit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.reinit && trk_q.st == ST_NORMAL && !idle_cmd) |=> (trk_q.ill && trk_q.st == ST_NORMAL));

endmodule

// File: tb/tb_lp_cke_tracker.sv
`timescale 1ns/1ps
module tb_lp_cke_tracker;
    localparam int TXP  = 2;
    localparam int TXSR = 4;
    localparam int XSR_EFF = (TXSR < 2) ? 2 : TXSR;
    localparam int MAX_CYC = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic       bank_open = 1'b0;
    logic       init_done = 1'b0;
    logic [2:0] pstate;
    logic [3:0] action;
    logic       illegal;
    logic       reinit_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int  m_st = 0;
    bit  m_ckep = 1;
    int  m_win = 0;
    bit  m_reinit = 0;
    int  e_act = 0;
    bit  e_ill = 0;
    string m_tag = "R1";

    always #4 clk = ~clk;

    lp_cke_tracker #(.T_XP(TXP), .T_XSR(TXSR)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd),
        .bank_open(bank_open), .init_done(init_done),
        .pstate(pstate), .action(action), .illegal(illegal),
        .reinit_req(reinit_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit idle_code(input logic [2:0] k);
        return (k == 3'd0) || (k == 3'd1);
    endfunction

    task automatic model_step(input bit c, input logic [2:0] k, input bit bo, input bit idn);
        bit nop = idle_code(k);
        int ns = m_st;
        bit ld = 0;
        int lv = 0;
        bit set_re = 0;
        e_ill = 0;
        e_act = 0;
        m_tag = "R9";
        if (m_st == 0) begin
            if (!m_ckep) begin
                e_ill = 1; m_tag = "R9";
            end else if (m_win > 0) begin
                e_ill = !c || !nop; m_tag = "R7";
            end else if (m_reinit && !nop) begin
                e_ill = 1; m_tag = "R8";
            end else if (!c) begin
                if (nop) begin
                    ns = bo ? 1 : 2; m_tag = bo ? "R2" : "R3";
                end else if (k == 3'd2 && !bo) begin
                    ns = 3; m_tag = "R4";
                end else if (k == 3'd4 && !bo) begin
                    ns = 4; m_tag = "R4";
                end else begin
                    e_ill = 1; m_tag = "R9";
                end
                if (!e_ill) e_act = ns;
            end
        end else begin
            if (!c) begin
                e_act = 4 + m_st; m_tag = "R5";
            end else if (nop) begin
                e_act = 8 + m_st; ns = 0; ld = 1;
                lv = (m_st == 3) ? XSR_EFF : TXP;
                set_re = (m_st == 4);
                m_tag = set_re ? "R8" : "R6";
            end else begin
                e_ill = 1; m_tag = "R6";
            end
        end
        if (ld) m_win = lv;
        else if (m_win > 0) m_win--;
        if (set_re) m_reinit = 1;
        else if (idn) m_reinit = 0;
        m_st = ns;
        m_ckep = c;
    endtask

    task automatic step(input bit c, input logic [2:0] k, input bit bo, input bit idn);
        cke = c; cmd = k; bank_open = bo; init_done = idn;
        model_step(c, k, bo, idn);
        @(negedge clk);
        chk(m_tag, "pstate", int'(pstate), m_st);
        chk(m_tag, "action", int'(action), e_act);
        chk(m_tag, "illegal", int'(illegal), int'(e_ill));
        chk(m_tag, "reinit_req", int'(reinit_req), int'(m_reinit));
    endtask

    initial begin
        #(MAX_CYC * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", "pstate", int'(pstate), 0);
        chk("R1", "action", int'(action), 0);
        chk("R1", "illegal", int'(illegal), 0);
        chk("R1", "reinit_req", int'(reinit_req), 0);
        rst_n = 1'b1;

        // directed: R2 active power-down, R5 hold with junk, R6 exit, R7 window
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        step(0, 5, 0, 0);
        step(0, 3, 1, 0);
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R3 precharge power-down, R6 illegal exit then legal exit
        step(0, 1, 0, 0);
        step(1, 6, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R4 self refresh, R7 window violation
        step(0, 2, 0, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 2, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R9 illegal entries
        step(0, 4, 1, 0);
        step(1, 0, 0, 0);
        step(0, 7, 0, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(0, 2, 1, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        // R4 deep power-down, R8 reinit sticky, gate and clear
        step(0, 4, 0, 0);
        step(0, 4, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 5, 0, 0);
        step(0, 2, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        step(1, 5, 0, 0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit c = cke;
            int r;
            logic [2:0] k;
            if (($urandom % 100) < 25) c = !c;
            r = int'($urandom % 10);
            if (r < 5)      k = 3'($urandom % 2);
            else if (r < 7) k = 3'd2;
            else if (r < 8) k = 3'd4;
            else            k = 3'($urandom % 8);
            step(c, k, bit'($urandom % 2), (($urandom % 100) < 4));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule